// File: doc/BRIEF.md
# Pipelined Burst Static Memory

This block is a clocked static memory whose word is split into byte lanes of nine bits each, two lanes by default. All control, address and write-data inputs are captured on the rising clock edge. On every edge the block decodes its select and strobe inputs into one of four actions. It can deselect, start a burst at the address on the pins, step a running burst to the next address, or repeat the current address to hold a burst. Read data passes through an output register. The output is presented as a data word plus a drive-enable flag, which stands in for a tristate bus. A low drive-enable means high impedance.

Two address strobes start bursts. The processor strobe has priority and always starts a read. The primary select gates it, so a processor strobe with that select inactive is ignored. The controller strobe starts a read or a write, depending on the lane write enables. When neither strobe is active, a running burst advances or holds, under control of the advance input. The burst address steps through the two low address bits and wraps inside an aligned group of four words.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted, and after it is released with no burst started, `dq_oe` is 0.
- R2: With `sel_n` low and `cpu_stb_n` low, and all three selects active (`sel_n`=0, `sel_hi`=1, `sel_lo_n`=0), the cycle starts a read at `addr`. The memory is not written, whatever the value of `wr_n`.
- R3: When `sel_n` is high, `cpu_stb_n` has no effect. The cycle decodes exactly as it would with `cpu_stb_n` high: a controller strobe, or a continue or hold of the running burst.
- R4: With `ctl_stb_n` low, `cpu_stb_n` high and all selects active, a burst starts at `addr`. It is a write of `din` if any bit of `wr_n` is 0, and a read otherwise.
- R5: A strobe that takes effect while any select is inactive is a deselect. It writes nothing, even with write enables low, and it ends the burst. `dq_oe` is 0 after the second rising edge that follows it.
- R6: With no strobe, an active burst and `adv_n` low, the cycle reads or writes the next address. The next address adds 1 to `addr[1:0]` modulo 4 and keeps the upper bits, so 3 is followed by 0 in the same aligned group.
- R7: With no strobe, an active burst and `adv_n` high, the cycle reads or writes the current address again.
- R8: `wr_n[0]` enables a write of `din[8:0]` and `wr_n[1]` enables a write of `din[17:9]`, both active low. A lane whose enable is high keeps its contents.
- R9: A read captured at rising edge k drives the word stored at its address on `dq_out`, with `dq_oe` high, from rising edge k+1 until rising edge k+2. This holds when the cycle at edge k+1 is not a write and `oe_n` is low.
- R10: `dq_oe` is 0 whenever `oe_n` is high, including while a read would be driving.
- R11: A write cycle sets `dq_oe` to 0 from the rising edge that captures it.
- R12: After a deselect, and after reset, cycles with no strobe neither write nor drive until a new burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| sel_n | input | 1 | Primary select, active low, also gates the processor strobe |
| sel_hi | input | 1 | Second select, active high |
| sel_lo_n | input | 1 | Third select, active low |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_n | input | LANES (2) | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, not registered |
| addr | input | AW (6) | Word address |
| din | input | LANES*LANE_W (18) | Write data |
| dq_out | output | LANES*LANE_W (18) | Read data from the output register |
| dq_oe | output | 1 | Drive enable for dq_out; 0 means high impedance |

## Verification
The bench keeps a behavioural model of the memory and its burst state, and it compares the drive flag and the driven word after every edge. Wrapping bursts that start at the last word of a group expose an adder that carries into the upper bits: such a design reads the next group instead of the first word of the current one. A processor strobe with write enables low, and a deselect with write enables low, both show up as corrupted read-back if the design writes. A processor strobe with the primary select high shows up as a wrong address if the design still honours it. A read followed by a write, or followed by a deselect, pins down the two release latencies: a design that uses the same latency for both drives one cycle too long or too short.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  // Decoded action for one clock edge
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_DESEL = 2'd1,
    OP_RD    = 2'd2,
    OP_WR    = 2'd3
  } op_e;

  // Address source for one clock edge
  typedef enum logic [1:0] {
    AS_HOLD = 2'd0,
    AS_LOAD = 2'd1,
    AS_NEXT = 2'd2
  } amode_e;

  localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
  import burst_sram_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] wr_n,
  input  logic             active,
  output op_e              op,
  output amode_e           amode,
  output logic [LANES-1:0] lane_we
);
  logic sel_all;
  logic cpu_go;
  logic any_we;

  assign sel_all = ~sel_n & sel_hi & ~sel_lo_n;
  assign cpu_go  = ~sel_n & ~cpu_stb_n;
  assign any_we  = ~&wr_n;

  always_comb begin
    op    = OP_IDLE;
    amode = AS_HOLD;
    if (cpu_go) begin
      if (sel_all) begin
        op    = OP_RD;
        amode = AS_LOAD;
      end else begin
        op = OP_DESEL;
      end
    end else if (!ctl_stb_n) begin
      if (sel_all) begin
        op    = any_we ? OP_WR : OP_RD;
        amode = AS_LOAD;
      end else begin
        op = OP_DESEL;
      end
    end else if (active) begin
      op    = any_we ? OP_WR : OP_RD;
      amode = adv_n ? AS_HOLD : AS_NEXT;
    end
  end

  assign lane_we = (op == OP_WR) ? ~wr_n : '0;
endmodule

// File: rtl/burst_sram_addr.sv
module burst_sram_addr
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  amode_e        amode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] eff_addr,
  output logic          active_q
);
  localparam int unsigned BW = BURST_W;

  logic [AW-1:0] cur_q;
  logic [AW-1:0] cur_d;
  logic          cur_en;
  logic          active_d;
  logic [BW-1:0] low_inc;

  assign low_inc = cur_q[BW-1:0] + BW'(1);

  always_comb begin
    unique case (amode)
      AS_LOAD: eff_addr = addr_in;
      AS_NEXT: eff_addr = {cur_q[AW-1:BW], low_inc};
      default: eff_addr = cur_q;
    endcase
  end

  always_comb begin
    cur_en   = (op == OP_RD) || (op == OP_WR);
    cur_d    = eff_addr;
    active_d = active_q;
    if (op == OP_DESEL) begin
      active_d = 1'b0;
    end else if (amode == AS_LOAD) begin
      active_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
      if (cur_en) begin
        cur_q <= cur_d;
      end
    end
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) begin
        bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/burst_sram_outreg.sv
module burst_sram_outreg
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic [AW-1:0] eff_addr,
  output logic [AW-1:0] rd_addr_q,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dout_q,
  output logic          drive_q
);
  logic rd_pend_q;
  logic rd_pend_d;
  logic drive_d;
  logic addr_en;

  always_comb begin
    rd_pend_d = (op == OP_RD);
    addr_en   = rd_pend_d;
    drive_d   = (op == OP_WR) ? 1'b0 : rd_pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      dout_q    <= '0;
      drive_q   <= 1'b0;
    end else begin
      rd_pend_q <= rd_pend_d;
      drive_q   <= drive_d;
      if (addr_en) begin
        rd_addr_q <= eff_addr;
      end
      if (rd_pend_q) begin
        dout_q <= rd_data;
      end
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             sel_hi,
  input  logic             sel_lo_n,
  input  logic             cpu_stb_n,
  input  logic             ctl_stb_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] wr_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  op_e              cyc_op;
  amode_e           cyc_amode;
  logic [LANES-1:0] lane_we;
  logic             active_q;
  logic [AW-1:0]    eff_addr;
  logic [AW-1:0]    rd_addr_q;
  logic [DW-1:0]    rd_data;
  logic [DW-1:0]    dout_q;
  logic             drive_q;

  // Reset asserts at once and releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  burst_sram_decode #(.LANES(LANES)) u_decode (
    .sel_n     (sel_n),
    .sel_hi    (sel_hi),
    .sel_lo_n  (sel_lo_n),
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .adv_n     (adv_n),
    .wr_n      (wr_n),
    .active    (active_q),
    .op        (cyc_op),
    .amode     (cyc_amode),
    .lane_we   (lane_we)
  );

  burst_sram_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .op       (cyc_op),
    .amode    (cyc_amode),
    .addr_in  (addr),
    .eff_addr (eff_addr),
    .active_q (active_q)
  );

  burst_sram_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .lane_we (rst_sync_n ? lane_we : '0),
    .wr_addr (eff_addr),
    .wr_data (din),
    .rd_addr (rd_addr_q),
    .rd_data (rd_data)
  );

  burst_sram_outreg #(.AW(AW), .DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op        (cyc_op),
    .eff_addr  (eff_addr),
    .rd_addr_q (rd_addr_q),
    .rd_data   (rd_data),
    .dout_q    (dout_q),
    .drive_q   (drive_q)
  );

  assign dq_out = dout_q;
  assign dq_oe  = drive_q & ~oe_n;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
  import burst_sram_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             sel_n,
  input logic             sel_hi,
  input logic             sel_lo_n,
  input logic             cpu_stb_n,
  input logic             ctl_stb_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             drive_q,
  input logic             active_q,
  input op_e              cyc_op,
  input logic [LANES-1:0] lane_we
);
  logic all_sel;
  logic stb_seen;

  assign all_sel  = ~sel_n & sel_hi & ~sel_lo_n;
  assign stb_seen = (~sel_n & ~cpu_stb_n) | ~ctl_stb_n;

  // R10
  oe_block_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    oe_n |-> !dq_oe);

  // R11
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc_op == OP_WR) |=> !dq_oe);

  // R5
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc_op == OP_DESEL) |-> ##2 !dq_oe);

  // R5
  desel_nowr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stb_seen && !all_sel) |-> (lane_we == '0));

  // R9
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc_op == OP_RD) ##1 (cyc_op != OP_WR) |=> drive_q);

  // R12
  idle_nowr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!active_q && !stb_seen) |-> (lane_we == '0));

  // R2
  cpu_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (all_sel && !cpu_stb_n) |-> (cyc_op == OP_RD));
endmodule

bind burst_sram burst_sram_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .sel_n      (sel_n),
  .sel_hi     (sel_hi),
  .sel_lo_n   (sel_lo_n),
  .cpu_stb_n  (cpu_stb_n),
  .ctl_stb_n  (ctl_stb_n),
  .oe_n       (oe_n),
  .dq_oe      (dq_oe),
  .drive_q    (drive_q),
  .active_q   (active_q),
  .cyc_op     (cyc_op),
  .lane_we    (lane_we)
);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;
  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, sel_hi, sel_lo_n, cpu_stb_n, ctl_stb_n, adv_n, oe_n;
  logic [1:0]    wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #10 clk = ~clk;

  burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n), .wr_n(wr_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string req = "R1";

  // Behavioural reference state
  logic [DW-1:0] ref_mem [64];
  bit            ref_act;
  int            ref_cur;
  bit            ref_pend;
  int            ref_paddr;
  bit            exp_drv;
  logic [DW-1:0] exp_dat;

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_act = 0; ref_cur = 0; ref_pend = 0; ref_paddr = 0; exp_drv = 0;
    end else begin
      bit            nd;
      logic [DW-1:0] ndat;
      bit            full;
      bit            we_any;
      int            kind;   // 0 none, 1 deselect, 2 read, 3 write
      int            a;
      nd     = ref_pend;
      ndat   = ref_mem[ref_paddr];
      full   = (sel_n == 0) && (sel_hi == 1) && (sel_lo_n == 0);
      we_any = (wr_n != 2'b11);
      kind   = 0;
      a      = ref_cur;
      if (sel_n == 0 && cpu_stb_n == 0) begin
        if (full) begin kind = 2; a = addr; ref_act = 1; end
        else begin kind = 1; ref_act = 0; end
      end else if (ctl_stb_n == 0) begin
        if (full) begin kind = we_any ? 3 : 2; a = addr; ref_act = 1; end
        else begin kind = 1; ref_act = 0; end
      end else if (ref_act) begin
        kind = we_any ? 3 : 2;
        if (adv_n == 0) a = (ref_cur / 4) * 4 + ((ref_cur + 1) % 4);
      end
      if (kind == 3) begin
        if (wr_n[0] == 0) ref_mem[a][8:0]  = din[8:0];
        if (wr_n[1] == 0) ref_mem[a][17:9] = din[17:9];
        nd = 0;
      end
      if (kind >= 2) ref_cur = a;
      ref_pend = (kind == 2);
      if (kind == 2) ref_paddr = a;
      exp_drv = nd;
      if (nd) exp_dat = ndat;
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit want;
      want = exp_drv && (oe_n == 0) && rst_n;
      total++;
      if (dq_oe !== want) begin
        bad++;
        $display("FAIL %s: dq_oe=%0b expected %0b at %0t", req, dq_oe, want, $time);
      end else if (want) begin
        total++;
        if (dq_out !== exp_dat) begin
          bad++;
          $display("FAIL %s: dq_out=%h expected %h at %0t", req, dq_out, exp_dat, $time);
        end
      end
    end
  end

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 32'h0a5f3) ^ 32'h15a5a);
  endfunction

  // Set one cycle of inputs; they are captured at the next rising edge
  task automatic cyc(input bit s_n, input bit s_hi, input bit s_lo_n,
                     input bit p_n, input bit c_n, input bit v_n,
                     input logic [1:0] w_n, input bit o_n,
                     input int a, input logic [DW-1:0] d);
    sel_n = s_n; sel_hi = s_hi; sel_lo_n = s_lo_n;
    cpu_stb_n = p_n; ctl_stb_n = c_n; adv_n = v_n;
    wr_n = w_n; oe_n = o_n; addr = AW'(a); din = d;
    @(posedge clk); #2;
  endtask

  task automatic ctl_wr(input int a, input logic [1:0] w, input logic [DW-1:0] d);
    cyc(0, 1, 0, 1, 0, 1, w, 0, a, d);
  endtask
  task automatic ctl_rd(input int a);
    cyc(0, 1, 0, 1, 0, 1, 2'b11, 0, a, '0);
  endtask
  task automatic step(input bit v_n, input logic [1:0] w, input logic [DW-1:0] d);
    cyc(0, 1, 0, 1, 1, v_n, w, 0, 0, d);
  endtask
  task automatic desel();
    cyc(0, 0, 0, 1, 0, 1, 2'b11, 0, 0, '0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    rst_n = 0;
    sel_n = 1; sel_hi = 0; sel_lo_n = 1; cpu_stb_n = 1; ctl_stb_n = 1;
    adv_n = 1; wr_n = 2'b11; oe_n = 0; addr = '0; din = '0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    // R1: idle after reset, a no-strobe write attempt must be ignored
    repeat (3) cyc(1, 0, 1, 1, 1, 1, 2'b11, 0, 0, '0);
    req = "R12";
    step(0, 2'b00, 18'h3ffff);
    step(1, 2'b00, 18'h3ffff);
    // R4: fill with controller-strobe writes
    req = "R4";
    for (int i = 0; i < 64; i++) ctl_wr(i, 2'b00, pat(i));
    ctl_rd(0);                    // reads back the word untouched by R12 stimulus
    ctl_rd(1);
    req = "R9";
    for (int i = 16; i < 24; i++) ctl_rd(i);
    step(1, 2'b11, '0);
    // R2: processor strobe with write enables low still reads
    req = "R2";
    cyc(0, 1, 0, 0, 1, 1, 2'b00, 0, 5, 18'h00000);
    cyc(0, 1, 0, 0, 0, 1, 2'b00, 0, 5, 18'h00000);
    ctl_rd(5);
    step(1, 2'b11, '0);
    // R6: wrapping read burst and wrapping write burst
    req = "R6";
    ctl_rd(7);
    step(0, 2'b11, '0); step(0, 2'b11, '0); step(0, 2'b11, '0); step(0, 2'b11, '0);
    ctl_wr(34, 2'b00, 18'h11111);
    step(0, 2'b00, 18'h22222); step(0, 2'b00, 18'h33333); step(0, 2'b00, 18'h04444);
    ctl_rd(32); step(0, 2'b11, '0); step(0, 2'b11, '0); step(0, 2'b11, '0);
    // R7: hold burst
    req = "R7";
    ctl_rd(9); step(1, 2'b11, '0); step(1, 2'b11, '0); step(0, 2'b11, '0); step(1, 2'b11, '0);
    ctl_wr(12, 2'b00, 18'h0abcd); step(1, 2'b00, 18'h15555); ctl_rd(12); ctl_rd(13);
    // R8: lane writes
    req = "R8";
    ctl_wr(3, 2'b10, 18'h3ffff); ctl_rd(3);
    ctl_wr(4, 2'b01, 18'h00000); ctl_rd(4); step(1, 2'b11, '0);
    // R5: deselect with writes enabled, and read then deselect
    req = "R5";
    cyc(0, 0, 0, 1, 0, 1, 2'b00, 0, 2, 18'h2aaaa);
    cyc(0, 1, 1, 0, 1, 1, 2'b00, 0, 2, 18'h2aaaa);
    ctl_rd(2); desel(); desel();
    ctl_rd(6); cyc(1, 1, 0, 0, 0, 1, 2'b00, 0, 6, 18'h1); step(1, 2'b11, '0);
    // R12: after deselect, no-strobe cycles do nothing
    req = "R12";
    step(0, 2'b00, 18'h12345); step(1, 2'b00, 18'h12345);
    ctl_rd(6); ctl_rd(7); step(1, 2'b11, '0);
    // R3: processor strobe ignored with primary select high
    req = "R3";
    ctl_rd(10);
    cyc(1, 1, 0, 0, 1, 0, 2'b11, 0, 40, '0);
    cyc(1, 1, 0, 0, 1, 1, 2'b11, 0, 40, '0);
    step(1, 2'b11, '0);
    // R10: output enable high blocks the drive
    req = "R10";
    ctl_rd(17); cyc(0, 1, 0, 1, 1, 1, 2'b11, 1, 0, '0);
    cyc(0, 1, 0, 1, 1, 1, 2'b11, 1, 0, '0); step(1, 2'b11, '0);
    // R11: read then write releases at the first edge
    req = "R11";
    ctl_rd(18); ctl_wr(19, 2'b00, 18'h0f0f0); ctl_rd(19); step(1, 2'b11, '0);
    req = "R9";
    repeat (3) step(1, 2'b11, '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL %s: watchdog expired, actual=hung expected=finished", req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule